// File: doc/BRIEF.md
# Masked-Write GPIO Block with Shared Interrupt

This block gives a chip sixteen general-purpose pins behind a small word-addressed register bus. Software drives pins through an output register that takes a per-pin write mask in the upper half of the data word, so one pin can change without a read-modify-write and without a race against other writers. A direction register picks input or output per pin, a level register returns the synchronized pad levels, and an interrupt-enable register gates the upper pins into one shared request.

The lower eight pins each drive a dedicated interrupt line that follows the synchronized pin level. The upper eight pins are each ANDed with their enable bit, and the eight results are ORed into a single request. This suits active-high sources. A control register holds a clock-enable bit (bit 0) and a block-reset bit (bit 1). After a hardware reset the block sits in its own reset with the clock off. It does nothing until software writes 1 to the control register.

Top module: `mgp_block`

## Requirements
- R1: After the hardware reset `rst`, the control register (index 0) reads 0x2, and `pad_oe`, `pad_out`, `irq_direct` and `irq_shared` are all 0.
- R2: A write to index 0 is always accepted, in every state, and bits 1:0 read back as written.
- R3: While control bit 1 is 1, the direction, output, interrupt-enable and synchronizer state clear to 0 at the next clock edge, and writes to those registers are ignored, so every pin is an input.
- R4: While control bit 0 is 0, writes to indices 1, 2 and 4 are ignored, the pin synchronizer holds its value, and all interrupt outputs are 0.
- R5: A write to index 2 sets pin n of `pad_out` to data bit n only when data bit n+16 is 1. Pins whose mask bit is 0 keep their value.
- R6: Index 1 is the direction register. Bit n at 1 drives `pad_oe[n]` high (output) and 0 makes the pin an input. It reads back as written.
- R7: Index 3 returns the pad levels in bits 15:0 after a two-flop synchronizer. A pad change shows after the second rising edge. Bits 31:16 read 0, and writes to index 3 have no effect.
- R8: While the block runs (control = 1), `irq_direct[i]` equals the synchronized level of pin i, for i from 0 to 7.
- R9: While the block runs, `irq_shared` is the OR over pins 8 to 15 of the synchronized level ANDed with the matching enable bit.
- R10: Index 4 (interrupt enable) reads back all 16 bits as written. Enable bits 0 to 7 do not affect any interrupt.
- R11: Reads of indices 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous hardware reset, active high |
| bus_we | input | 1 | Register write strobe, sampled on the rising edge |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data (upper half is the output mask) |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 16 | Asynchronous pad levels |
| pad_out | output | 16 | Output register value toward the pads |
| pad_oe | output | 16 | Per-pin output enable |
| irq_direct | output | 8 | Dedicated requests for pins 0 to 7 |
| irq_shared | output | 1 | Enabled-OR request for pins 8 to 15 |

## Verification
The bench probes masks that are partial, empty and single-bit. A design that treated the mask as a plain write would clobber untouched pins, and one that ignored the data half would never clear a pin. It times pin-state reads at the first and second edge after a pad change, which exposes a missing or extra synchronizer stage. It also sets enable bits 0 to 7 under high upper pins, to catch an enable map shifted down to the low byte. Finally it writes registers while the clock is off and while held in reset, and checks that the pin state freezes. A design that gated the wrong control bit would let those writes land or keep driving pads.

// File: rtl/mgp_pkg.sv
package mgp_pkg;

    typedef enum logic [2:0] {
        RIDX_CTRL = 3'd0,
        RIDX_DIR  = 3'd1,
        RIDX_OUT  = 3'd2,
        RIDX_LVL  = 3'd3,
        RIDX_IEN  = 3'd4
    } reg_idx_e;

    typedef struct packed {
        logic hold_rst;   // bit 1
        logic clk_on;     // bit 0
    } blk_ctrl_t;

    localparam blk_ctrl_t CTRL_RESET_VAL = '{hold_rst: 1'b1, clk_on: 1'b0};

    function automatic logic ctrl_running(input blk_ctrl_t c);
        return c.clk_on && !c.hold_rst;
    endfunction

    function automatic logic ctrl_writable(input blk_ctrl_t c);
        return c.clk_on && !c.hold_rst;
    endfunction

endpackage

// File: rtl/mgp_ctrl.sv
module mgp_ctrl
    import mgp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_ctrl,
    input  logic [1:0] wdata,
    output blk_ctrl_t ctrl_q,
    output logic      run,
    output logic      hold
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET_VAL;
        end else if (wr_ctrl) begin
            ctrl_q <= blk_ctrl_t'(wdata);
        end
    end

    assign run  = ctrl_running(ctrl_q);
    assign hold = ctrl_q.hold_rst;
endmodule

// File: rtl/mgp_sync.sv
module mgp_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            stage1 <= '0;
            stage2 <= '0;
        end else if (en) begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/mgp_regfile.sv
module mgp_regfile #(
    parameter int NPINS = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hold,
    input  logic               wr_ok,
    input  logic               wr_dir,
    input  logic               wr_out,
    input  logic               wr_ien,
    input  logic [2*NPINS-1:0] wdata,
    output logic [NPINS-1:0]   dir_q,
    output logic [NPINS-1:0]   out_q,
    output logic [NPINS-1:0]   ien_q
);
    localparam int MASK_LSB = NPINS;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            dir_q <= '0;
            ien_q <= '0;
        end else if (wr_ok) begin
            if (wr_dir) dir_q <= wdata[NPINS-1:0];
            if (wr_ien) ien_q <= wdata[NPINS-1:0];
        end
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_outbit
        always_ff @(posedge clk) begin
            if (rst || hold) begin
                out_q[p] <= 1'b0;
            end else if (wr_ok && wr_out && wdata[MASK_LSB + p]) begin
                out_q[p] <= wdata[p];
            end
        end
    end
endmodule

// File: rtl/mgp_irq.sv
module mgp_irq #(
    parameter int NPINS = 16,
    parameter int SPLIT = 8
) (
    input  logic             run,
    input  logic [NPINS-1:0] lvl,
    input  logic [NPINS-1:0] ien,
    output logic [SPLIT-1:0] irq_direct,
    output logic             irq_shared
);
    localparam int NSHARE = NPINS - SPLIT;

    logic [NSHARE-1:0] gated;

    for (genvar k = 0; k < NSHARE; k++) begin : g_gate
        assign gated[k] = lvl[SPLIT + k] & ien[SPLIT + k];
    end

    assign irq_direct = lvl[SPLIT-1:0] & {SPLIT{run}};
    assign irq_shared = run & (|gated);
endmodule

// File: rtl/mgp_block.sv
module mgp_block
    import mgp_pkg::*;
#(
    parameter int NPINS = 16,
    parameter int SPLIT = 8,
    localparam int BUS_W = 2 * NPINS,
    localparam int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic [SPLIT-1:0]  irq_direct,
    output logic              irq_shared
);
    blk_ctrl_t        ctrl_q;
    logic             run;
    logic             hold;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] out_q;
    logic [NPINS-1:0] ien_q;
    logic [NPINS-1:0] lvl_q;
    reg_idx_e         idx;

    assign idx = reg_idx_e'(bus_addr);

    mgp_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_ctrl (bus_we && idx == RIDX_CTRL),
        .wdata   (bus_wdata[1:0]),
        .ctrl_q  (ctrl_q),
        .run     (run),
        .hold    (hold)
    );

    mgp_regfile #(.NPINS(NPINS)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .hold   (hold),
        .wr_ok  (ctrl_writable(ctrl_q)),
        .wr_dir (bus_we && idx == RIDX_DIR),
        .wr_out (bus_we && idx == RIDX_OUT),
        .wr_ien (bus_we && idx == RIDX_IEN),
        .wdata  (bus_wdata),
        .dir_q  (dir_q),
        .out_q  (out_q),
        .ien_q  (ien_q)
    );

    mgp_sync #(.W(NPINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .clr (hold),
        .en  (ctrl_q.clk_on),
        .d   (pad_in),
        .q   (lvl_q)
    );

    mgp_irq #(.NPINS(NPINS), .SPLIT(SPLIT)) u_irq (
        .run        (run),
        .lvl        (lvl_q),
        .ien        (ien_q),
        .irq_direct (irq_direct),
        .irq_shared (irq_shared)
    );

    always_comb begin
        bus_rdata = '0;
        case (idx)
            RIDX_CTRL: bus_rdata[1:0]       = ctrl_q;
            RIDX_DIR:  bus_rdata[NPINS-1:0] = dir_q;
            RIDX_OUT:  bus_rdata[NPINS-1:0] = out_q;
            RIDX_LVL:  bus_rdata[NPINS-1:0] = lvl_q;
            RIDX_IEN:  bus_rdata[NPINS-1:0] = ien_q;
            default:   bus_rdata            = '0;
        endcase
    end

    assign pad_out = out_q;
    assign pad_oe  = dir_q;
endmodule

// File: rtl/mgp_check.sv
module mgp_check
    import mgp_pkg::*;
#(
    parameter int NPINS = 16,
    parameter int SPLIT = 8,
    localparam int BUS_W = 2 * NPINS
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_we,
    input logic [2:0]       bus_addr,
    input logic [BUS_W-1:0] bus_wdata,
    input logic [NPINS-1:0] pad_out,
    input logic [NPINS-1:0] pad_oe,
    input logic [SPLIT-1:0] irq_direct,
    input logic             irq_shared,
    input blk_ctrl_t        ctrl_q,
    input logic [NPINS-1:0] ien_q
);
    logic running;
    assign running = ctrl_q.clk_on && !ctrl_q.hold_rst;

    assert_hold_clears_R3: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.hold_rst |=> (pad_oe == '0 && pad_out == '0));

    assert_masked_write_R5: assert property (@(posedge clk) disable iff (rst)
        (running && bus_we && bus_addr == 3'(RIDX_OUT)) |=>
        pad_out == (($past(bus_wdata[NPINS-1:0]) & $past(bus_wdata[BUS_W-1:NPINS]))
                  | ($past(pad_out) & ~$past(bus_wdata[BUS_W-1:NPINS]))));

    assert_clock_off_frozen_R4: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.clk_on && !ctrl_q.hold_rst) |=>
        ($stable(pad_out) && $stable(pad_oe) && $stable(ien_q)));

    assert_quiet_when_idle_R4: assert property (@(posedge clk) disable iff (rst)
        !running |-> (irq_direct == '0 && !irq_shared));

    assert_shared_needs_enable_R9: assert property (@(posedge clk) disable iff (rst)
        irq_shared |-> (ien_q[NPINS-1:SPLIT] != '0));
endmodule

bind mgp_block mgp_check #(.NPINS(NPINS), .SPLIT(SPLIT)) u_mgp_check (
    .clk        (clk),
    .rst        (rst),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .irq_direct (irq_direct),
    .irq_shared (irq_shared),
    .ctrl_q     (ctrl_q),
    .ien_q      (ien_q)
);

// File: tb/mgp_block_bench.sv
module mgp_block_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic [15:0] pad_in = 16'd0;
    logic [15:0] pad_out;
    logic [15:0] pad_oe;
    logic [7:0]  irq_direct;
    logic        irq_shared;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    mgp_block u_mgp_block (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq_direct(irq_direct),
        .irq_shared(irq_shared)
    );

    // behavioural reference model
    logic [1:0]  m_ctrl;
    logic [15:0] m_dir, m_out, m_ien, m_s1, m_s2;

    always @(posedge clk) begin
        logic [1:0]  nc;
        logic [15:0] nd, no, ni, n1, n2;
        if (rst) begin
            m_ctrl = 2'b10; m_dir = 0; m_out = 0; m_ien = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            nc = m_ctrl; nd = m_dir; no = m_out; ni = m_ien; n1 = m_s1; n2 = m_s2;
            if (bus_we && bus_addr == 3'd0) nc = bus_wdata[1:0];
            if (m_ctrl[1]) begin
                nd = 0; no = 0; ni = 0; n1 = 0; n2 = 0;
            end else if (m_ctrl[0]) begin
                if (bus_we && bus_addr == 3'd1) nd = bus_wdata[15:0];
                if (bus_we && bus_addr == 3'd4) ni = bus_wdata[15:0];
                if (bus_we && bus_addr == 3'd2)
                    for (int b = 0; b < 16; b++)
                        if (bus_wdata[b+16]) no[b] = bus_wdata[b];
                n2 = m_s1; n1 = pad_in;
            end
            m_ctrl = nc; m_dir = nd; m_out = no; m_ien = ni; m_s1 = n1; m_s2 = n2;
        end
    end

    function automatic string addr_tag(input logic [2:0] a);
        case (a)
            3'd0: return "R2";
            3'd1: return "R6";
            3'd2: return "R5";
            3'd3: return "R7";
            3'd4: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic        run;
            logic [31:0] rexp;
            run = (m_ctrl == 2'b01);
            case (bus_addr)
                3'd0: rexp = {30'd0, m_ctrl};
                3'd1: rexp = {16'd0, m_dir};
                3'd2: rexp = {16'd0, m_out};
                3'd3: rexp = {16'd0, m_s2};
                3'd4: rexp = {16'd0, m_ien};
                default: rexp = 32'd0;
            endcase
            check("R5 model pad_out", {16'd0, pad_out}, {16'd0, m_out});
            check("R6 model pad_oe", {16'd0, pad_oe}, {16'd0, m_dir});
            check("R8 model irq_direct", {24'd0, irq_direct}, run ? {24'd0, m_s2[7:0]} : 32'd0);
            check("R9 model irq_shared", {31'd0, irq_shared},
                  {31'd0, run & (|(m_s2[15:8] & m_ien[15:8]))});
            check({addr_tag(bus_addr), " model rdata"}, bus_rdata, rexp);
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [2:0] a, input logic [31:0] exp);
        bus_addr = a; #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1: reset state
        rd("R1 ctrl after reset", 3'd0, 32'h2);
        check("R1 pad_oe", {16'd0, pad_oe}, 32'd0);
        check("R1 pad_out", {16'd0, pad_out}, 32'd0);
        check("R1 irqs", {23'd0, irq_shared, irq_direct}, 32'd0);

        // R3: writes ignored while held
        wr(3'd1, 32'h0000_FFFF);
        rd("R3 dir ignored in reset", 3'd1, 32'h0);
        wr(3'd0, 32'h3);
        rd("R2 ctrl readback 3", 3'd0, 32'h3);
        wr(3'd1, 32'h0000_FFFF);
        rd("R3 dir ignored reset+clk", 3'd1, 32'h0);

        // run
        wr(3'd0, 32'h1);
        rd("R2 ctrl readback 1", 3'd0, 32'h1);
        wr(3'd1, 32'h0000_00FF);
        check("R6 pad_oe", {16'd0, pad_oe}, 32'h00FF);
        rd("R6 dir readback", 3'd1, 32'h00FF);

        // R5 masked writes
        wr(3'd2, 32'hFFFF_A5A5);
        check("R5 full mask", {16'd0, pad_out}, 32'hA5A5);
        wr(3'd2, 32'h0F00_FFFF);
        check("R5 partial mask", {16'd0, pad_out}, 32'hAFA5);
        wr(3'd2, 32'h0000_0000);
        check("R5 empty mask", {16'd0, pad_out}, 32'hAFA5);
        wr(3'd2, 32'h0001_0000);
        check("R5 single clear", {16'd0, pad_out}, 32'hAFA4);
        rd("R5 out readback", 3'd2, 32'hAFA4);

        // R7 / R8 synchronizer timing
        bus_addr = 3'd3;
        pad_in = 16'h0081;
        tick(1);
        rd("R7 level after 1 edge", 3'd3, 32'h0);
        tick(1);
        rd("R7 level after 2 edges", 3'd3, 32'h0081);
        check("R8 direct irqs", {24'd0, irq_direct}, 32'h81);
        wr(3'd3, 32'hFFFF_FFFF);
        rd("R7 level not writable", 3'd3, 32'h0081);

        // R10 / R9 shared interrupt
        wr(3'd4, 32'h0000_00FF);
        pad_in = 16'hFF00;
        tick(3);
        check("R10 low enables no effect", {31'd0, irq_shared}, 32'd0);
        check("R8 direct irqs low", {24'd0, irq_direct}, 32'd0);
        wr(3'd4, 32'h0000_0400);
        check("R9 shared raised", {31'd0, irq_shared}, 32'd1);
        rd("R10 ien readback", 3'd4, 32'h0400);
        pad_in = 16'hFB00;
        tick(2);
        check("R9 shared drops", {31'd0, irq_shared}, 32'd0);

        // R4 clock off
        wr(3'd0, 32'h0);
        wr(3'd2, 32'hFFFF_0000);
        check("R4 out write ignored", {16'd0, pad_out}, 32'hAFA4);
        wr(3'd4, 32'h0000_FF00);
        rd("R4 ien write ignored", 3'd4, 32'h0400);
        pad_in = 16'h1234;
        tick(3);
        rd("R4 level frozen", 3'd3, 32'hFB00);
        check("R4 irqs quiet", {23'd0, irq_shared, irq_direct}, 32'd0);

        // R3 hold reset clears state
        wr(3'd0, 32'h2);
        tick(1);
        check("R3 pad_oe cleared", {16'd0, pad_oe}, 32'd0);
        check("R3 pad_out cleared", {16'd0, pad_out}, 32'd0);
        rd("R3 ien cleared", 3'd4, 32'd0);
        rd("R3 level cleared", 3'd3, 32'd0);

        // R11 unmapped
        rd("R11 index 6", 3'd6, 32'd0);
        rd("R11 index 5", 3'd5, 32'd0);

        tick(2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule